// File: doc/BRIEF.md
# I2C Controller Queue and Status Block

This block sits between an I2C bus engine and the register file of an I2C controller. It holds two queues of 9-bit words, each eight entries deep. Software fills the transmit queue and the bus engine drains it. The bus engine fills the receive queue and software drains it. Each read port holds the most recently popped word. The block also builds the 16-bit status word that software reads, masks it with an interrupt-enable word, and drives one interrupt line.

Each queue reports a 3-bit fill level. Because eight entries do not fit in three bits, a full queue reads as level 0, and a separate full flag tells it apart from an empty queue. Bus events from the engine set sticky status bits, and so do the queue error conditions. Software clears these bits by writing ones to a clear port. A soft-reset pulse empties both queues at once. If that pulse arrives while received words are still pending, it raises an error, so software should drain the receive queue first.

Top module: `i2c_queue_status`

## Requirements
- R1: Each queue is a first-in first-out store of 8 words of 9 bits. Transmit words go in from the register side and come out at the engine side. Receive words go in from the engine side and come out at the register side. A pop of a non-empty queue places the oldest word on that queue's read port in the cycle after the pop, and the port holds it until the next successful pop.
- R2: Each level output is the entry count modulo 8, in 3 bits. With 8 entries it reads 0. Receive-full then shows in status bit 0, and transmit-full shows in status bits 1 and 13.
- R3: Status bits that follow live state: bit 0 is receive queue full, bit 1 is transmit queue full, bit 2 is transmit queue empty, bit 9 is the bus-busy input, bit 12 is transmit count at least 4, bit 13 is transmit queue full, and bit 14 is receive count at least 4.
- R4: The interrupt-enable word uses the status bit positions, is loaded whole on a write, and the interrupt line is high exactly when some status bit and its enable bit are both 1.
- R5: Engine event pulses set sticky status bits, which stay set until cleared: slave-addressed sets bit 6, STOP seen sets bit 7, arbitration lost sets bit 8, NACK sets bit 10, and repeated START seen sets bit 11.
- R6: A clear write resets each sticky bit (3, 4, 5, 6, 7, 8, 10, 11, 15) whose clear-data bit is 1. Bits written as 0 are left alone. A set condition in the same cycle wins over the clear.
- R7: A soft-reset pulse leaves both queues empty in the next cycle. If the receive queue held at least one word when the pulse arrived, it also sets sticky bit 5. An empty receive queue leaves bit 5 unchanged.
- R8: Popping an empty queue leaves its read port at the last value and sets sticky bit 15.
- R9: Pushing into a full queue discards the word and leaves the contents unchanged. An engine push into the full receive queue sets sticky bit 3, and a register push into the full transmit queue sets sticky bit 4.
- R10: After reset both queues are empty, the enable word is 0, the interrupt is low, and with bus-busy low the status word is 0x0004.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Pulse that empties both queues |
| reg_tx_push | input | 1 | Register side: push a word into the transmit queue |
| reg_tx_wdata | input | 9 | Word to push into the transmit queue |
| reg_rx_pop | input | 1 | Register side: pop the receive queue |
| reg_rx_rdata | output | 9 | Last word popped from the receive queue |
| eng_tx_pop | input | 1 | Engine side: pop the transmit queue |
| eng_tx_data | output | 9 | Last word popped from the transmit queue |
| eng_rx_push | input | 1 | Engine side: push a word into the receive queue |
| eng_rx_data | input | 9 | Word to push into the receive queue |
| ev_slave_addr | input | 1 | Pulse: the controller was addressed as a slave |
| ev_stop | input | 1 | Pulse: STOP condition seen |
| ev_arb_lost | input | 1 | Pulse: arbitration lost |
| ev_nack | input | 1 | Pulse: NACK received |
| ev_rstart | input | 1 | Pulse: repeated START seen |
| bus_busy | input | 1 | Live bus-busy level |
| ien_we | input | 1 | Load the interrupt-enable word |
| ien_wdata | input | 16 | New interrupt-enable word |
| clr_we | input | 1 | Apply a write-one-to-clear to the sticky bits |
| clr_wdata | input | 16 | Clear mask |
| status | output | 16 | Status word |
| ien | output | 16 | Current interrupt-enable word |
| irq | output | 1 | Interrupt line |
| tx_level | output | 3 | Transmit entry count modulo 8 |
| rx_level | output | 3 | Receive entry count modulo 8 |

## Verification
A wrong count register shows up at the level outputs and at the full, empty and half flags in the cycle after the offending push or pop. The level wrap makes count 8 and count 0 look alike, so each check compares the level together with the full bit. A wrong read or write pointer shows up as a word out of order on a read port at the next pop, including after a dropped push into a full queue. A sticky bit that is lost, stuck, or cleared when it should win shows up in the status word and on the interrupt line one cycle after the event or the clear write.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
    localparam int ST_W      = 16;
    localparam int WORD_W    = 9;
    localparam int Q_DEPTH   = 8;

    localparam int B_RX_FULL  = 0;
    localparam int B_TX_FULL  = 1;
    localparam int B_TX_EMPTY = 2;
    localparam int B_RX_OVR   = 3;
    localparam int B_TX_OVR   = 4;
    localparam int B_SRST_ERR = 5;
    localparam int B_SLV_ADDR = 6;
    localparam int B_STOP     = 7;
    localparam int B_ARB      = 8;
    localparam int B_BUSY     = 9;
    localparam int B_NACK     = 10;
    localparam int B_RSTART   = 11;
    localparam int B_TX_HALF  = 12;
    localparam int B_TX_FULL2 = 13;
    localparam int B_RX_HALF  = 14;
    localparam int B_UNDER    = 15;

    // positions that hold state until written with a one on the clear port
    localparam logic [ST_W-1:0] STICKY_MASK = 16'h8DF8;
endpackage

// File: rtl/i2cq_queue.sv
module i2cq_queue #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CNT_W-1:0] count,
    output logic             push_drop,
    output logic             pop_empty
);
    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] cnt;
        logic [WIDTH-1:0] rdata;
    } q_state_t;

    q_state_t s_d, s_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop, is_full, is_empty;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        is_full   = (s_q.cnt == CNT_W'(DEPTH));
        is_empty  = (s_q.cnt == '0);
        do_push   = push && !flush && !is_full;
        do_pop    = pop && !flush && !is_empty;
        push_drop = push && !flush && is_full;
        pop_empty = pop && !flush && is_empty;
        s_d = s_q;
        if (flush) begin
            s_d.wptr = '0;
            s_d.rptr = '0;
            s_d.cnt  = '0;
        end else begin
            if (do_push) s_d.wptr = ptr_next(s_q.wptr);
            if (do_pop) begin
                s_d.rptr  = ptr_next(s_q.rptr);
                s_d.rdata = mem_q[s_q.rptr];
            end
            unique case ({do_push, do_pop})
                2'b10:   s_d.cnt = s_q.cnt + 1'b1;
                2'b01:   s_d.cnt = s_q.cnt - 1'b1;
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[s_q.wptr] <= wdata;
    end

    assign rdata = s_q.rdata;
    assign count = s_q.cnt;

    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(DEPTH));
    p_push_grows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !flush && !is_full) |=> (count == $past(count) + 1'b1));
    p_full_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !flush && is_full) |=> (count == CNT_W'(DEPTH)));
    p_empty_pop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !flush && is_empty) |=> $stable(rdata));
    p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));
endmodule

// File: rtl/i2cq_flags.sv
module i2cq_flags #(
    parameter int W = 16,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic         clr_we,
    input  logic [W-1:0] clr_wdata,
    output logic [W-1:0] flags
);
    logic [W-1:0] flags_d, flags_q, clr_eff;

    always_comb begin
        clr_eff = clr_we ? clr_wdata : '0;
        flags_d = ((flags_q & ~clr_eff) | set) & MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (MASK[i]) begin : g_sticky
            p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (flags[i] && !(clr_we && clr_wdata[i])) |=> flags[i]);
            p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_we && clr_wdata[i] && !set[i]) |=> !flags[i]);
            p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
                set[i] |=> flags[i]);
        end else begin : g_none
            p_unused_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
                !flags[i]);
        end
    end
endmodule

// File: rtl/i2c_queue_status.sv
module i2c_queue_status
    import i2cq_pkg::*;
#(
    parameter int WIDTH = WORD_W,
    parameter int DEPTH = Q_DEPTH,
    localparam int LVL_W = $clog2(DEPTH),
    localparam int CNT_W = LVL_W + 1,
    localparam int HALF  = DEPTH / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             reg_tx_push,
    input  logic [WIDTH-1:0] reg_tx_wdata,
    input  logic             reg_rx_pop,
    output logic [WIDTH-1:0] reg_rx_rdata,
    input  logic             eng_tx_pop,
    output logic [WIDTH-1:0] eng_tx_data,
    input  logic             eng_rx_push,
    input  logic [WIDTH-1:0] eng_rx_data,
    input  logic             ev_slave_addr,
    input  logic             ev_stop,
    input  logic             ev_arb_lost,
    input  logic             ev_nack,
    input  logic             ev_rstart,
    input  logic             bus_busy,
    input  logic             ien_we,
    input  logic [ST_W-1:0]  ien_wdata,
    input  logic             clr_we,
    input  logic [ST_W-1:0]  clr_wdata,
    output logic [ST_W-1:0]  status,
    output logic [ST_W-1:0]  ien,
    output logic             irq,
    output logic [LVL_W-1:0] tx_level,
    output logic [LVL_W-1:0] rx_level
);
    typedef struct packed {
        logic [ST_W-1:0] ien;
    } top_state_t;

    top_state_t st_d, st_q;
    logic [CNT_W-1:0] tx_cnt, rx_cnt;
    logic tx_drop, tx_under, rx_drop, rx_under;
    logic [ST_W-1:0] set_vec, sticky;

    i2cq_queue #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(soft_rst),
        .push(reg_tx_push), .wdata(reg_tx_wdata), .pop(eng_tx_pop),
        .rdata(eng_tx_data), .count(tx_cnt),
        .push_drop(tx_drop), .pop_empty(tx_under)
    );

    i2cq_queue #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(soft_rst),
        .push(eng_rx_push), .wdata(eng_rx_data), .pop(reg_rx_pop),
        .rdata(reg_rx_rdata), .count(rx_cnt),
        .push_drop(rx_drop), .pop_empty(rx_under)
    );

    always_comb begin
        set_vec              = '0;
        set_vec[B_RX_OVR]    = rx_drop;
        set_vec[B_TX_OVR]    = tx_drop;
        set_vec[B_SRST_ERR]  = soft_rst && (rx_cnt != '0);
        set_vec[B_SLV_ADDR]  = ev_slave_addr;
        set_vec[B_STOP]      = ev_stop;
        set_vec[B_ARB]       = ev_arb_lost;
        set_vec[B_NACK]      = ev_nack;
        set_vec[B_RSTART]    = ev_rstart;
        set_vec[B_UNDER]     = tx_under || rx_under;
    end

    i2cq_flags #(.W(ST_W), .MASK(STICKY_MASK)) u_flags (
        .clk(clk), .rst_n(rst_n), .set(set_vec),
        .clr_we(clr_we), .clr_wdata(clr_wdata), .flags(sticky)
    );

    always_comb begin
        st_d = st_q;
        if (ien_we) st_d.ien = ien_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        status             = sticky;
        status[B_RX_FULL]  = (rx_cnt == CNT_W'(DEPTH));
        status[B_TX_FULL]  = (tx_cnt == CNT_W'(DEPTH));
        status[B_TX_EMPTY] = (tx_cnt == '0);
        status[B_BUSY]     = bus_busy;
        status[B_TX_HALF]  = (tx_cnt >= CNT_W'(HALF));
        status[B_TX_FULL2] = (tx_cnt == CNT_W'(DEPTH));
        status[B_RX_HALF]  = (rx_cnt >= CNT_W'(HALF));
    end

    assign ien      = st_q.ien;
    assign irq      = |(status & st_q.ien);
    assign tx_level = tx_cnt[LVL_W-1:0];
    assign rx_level = rx_cnt[LVL_W-1:0];

    p_irq_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> !irq);
    p_ien_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ien_we |=> (ien == $past(ien_wdata)));
    p_srst_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && rx_level != '0) |=> status[B_SRST_ERR]);
    p_full_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        status[B_RX_FULL] |-> (rx_level == '0 && !status[B_RX_HALF] == 1'b0));
endmodule

// File: tb/i2c_queue_status_tb.sv
module i2c_queue_status_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 0, reg_tx_push = 0, reg_rx_pop = 0, eng_tx_pop = 0, eng_rx_push = 0;
    logic [8:0] reg_tx_wdata = '0, eng_rx_data = '0;
    logic ev_slave_addr = 0, ev_stop = 0, ev_arb_lost = 0, ev_nack = 0, ev_rstart = 0;
    logic bus_busy = 0, ien_we = 0, clr_we = 0;
    logic [15:0] ien_wdata = '0, clr_wdata = '0;
    logic [8:0] reg_rx_rdata, eng_tx_data;
    logic [15:0] status, ien;
    logic irq;
    logic [2:0] tx_level, rx_level;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    i2c_queue_status u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .reg_tx_push(reg_tx_push), .reg_tx_wdata(reg_tx_wdata),
        .reg_rx_pop(reg_rx_pop), .reg_rx_rdata(reg_rx_rdata),
        .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
        .ev_slave_addr(ev_slave_addr), .ev_stop(ev_stop), .ev_arb_lost(ev_arb_lost),
        .ev_nack(ev_nack), .ev_rstart(ev_rstart), .bus_busy(bus_busy),
        .ien_we(ien_we), .ien_wdata(ien_wdata), .clr_we(clr_we), .clr_wdata(clr_wdata),
        .status(status), .ien(ien), .irq(irq), .tx_level(tx_level), .rx_level(rx_level)
    );

    // {op (0 push tx, 1 pop tx), word pushed or expected, expected tx level}
    localparam logic [12:0] VEC [10] = '{
        {1'b0, 9'h101, 3'd1}, {1'b0, 9'h0A2, 3'd2}, {1'b0, 9'h1FF, 3'd3},
        {1'b1, 9'h101, 3'd2}, {1'b0, 9'h033, 3'd3}, {1'b1, 9'h0A2, 3'd2},
        {1'b1, 9'h1FF, 3'd1}, {1'b1, 9'h033, 3'd0}, {1'b1, 9'h033, 3'd0},
        {1'b0, 9'h000, 3'd1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // inputs are set before calling; one edge, then everything released at the negedge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        soft_rst = 0; reg_tx_push = 0; reg_rx_pop = 0; eng_tx_pop = 0; eng_rx_push = 0;
        ev_slave_addr = 0; ev_stop = 0; ev_arb_lost = 0; ev_nack = 0; ev_rstart = 0;
        ien_we = 0; clr_we = 0;
    endtask

    task automatic clear_all();
        clr_we = 1; clr_wdata = 16'hFFFF; tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset state
        chk("R10 status", status, 16'h0004);
        chk("R10 irq", irq, 0);
        chk("R10 ien", ien, 0);
        chk("R10 levels", {tx_level, rx_level}, 0);

        // R1 table walk on the transmit queue
        for (int i = 0; i < 10; i++) begin
            if (VEC[i][12] == 1'b0) begin
                reg_tx_push = 1; reg_tx_wdata = VEC[i][11:3];
            end else begin
                eng_tx_pop = 1;
            end
            tick();
            chk("R2 tx level", tx_level, VEC[i][2:0]);
            if (VEC[i][12]) chk("R1 tx order", eng_tx_data, VEC[i][11:3]);
        end
        chk("R8 underflow sticky", status[15], 1);
        clr_we = 1; clr_wdata = 16'h8000; tick();
        chk("R6 clear underflow", status[15], 0);
        eng_tx_pop = 1; tick();
        chk("R1 last word", eng_tx_data, 9'h000);

        // R2 R3 R9 fill transmit queue to 8, then push a 9th
        for (int i = 0; i < 8; i++) begin
            reg_tx_push = 1; reg_tx_wdata = 9'(i + 16); tick();
            if (i == 3) chk("R3 tx half at 4", status[12], 1);
        end
        chk("R2 tx level wraps", tx_level, 0);
        chk("R3 tx full bits", {status[13], status[2], status[1]}, 3'b101);
        reg_tx_push = 1; reg_tx_wdata = 9'h1AA; tick();
        chk("R9 tx overflow bit4", status[4], 1);
        for (int i = 0; i < 8; i++) begin
            eng_tx_pop = 1; tick();
            chk("R9 contents kept", eng_tx_data, 9'(i + 16));
        end
        chk("R3 tx empty again", status[2], 1);

        // R2 R3 R9 receive side
        for (int i = 0; i < 8; i++) begin
            eng_rx_push = 1; eng_rx_data = 9'(i * 3 + 1); tick();
            if (i == 3) chk("R3 rx half", {status[14], rx_level}, {1'b1, 3'd4});
        end
        chk("R2 rx full wraps", {status[0], rx_level}, {1'b1, 3'd0});
        eng_rx_push = 1; eng_rx_data = 9'h155; tick();
        chk("R9 rx overflow bit3", status[3], 1);
        reg_rx_pop = 1; tick();
        chk("R1 rx oldest", reg_rx_rdata, 9'h001);
        chk("R2 rx level 7", rx_level, 7);

        // R7 soft reset with data pending
        clear_all();
        soft_rst = 1; tick();
        chk("R7 queues empty", {tx_level, rx_level, status[0], status[14]}, 0);
        chk("R7 busy error set", status[5], 1);
        reg_rx_pop = 1; tick();
        chk("R8 rx read port held", reg_rx_rdata, 9'h001);
        chk("R8 rx underflow", status[15], 1);
        clear_all();
        soft_rst = 1; tick();
        chk("R7 no error when empty", status[5], 0);

        // R5 R4 events and interrupt
        ev_stop = 1; tick();
        chk("R5 stop sticky", status[7], 1);
        chk("R4 irq masked", irq, 0);
        ien_we = 1; ien_wdata = 16'h0080; tick();
        chk("R4 ien loaded", ien, 16'h0080);
        chk("R4 irq on", irq, 1);
        ev_slave_addr = 1; ev_arb_lost = 1; ev_nack = 1; ev_rstart = 1; tick();
        chk("R5 event bits", status & 16'h0DC0, 16'h0DC0);
        clr_we = 1; clr_wdata = 16'h0000; tick();
        chk("R6 zero clear no effect", status & 16'h0DC0, 16'h0DC0);
        clr_we = 1; clr_wdata = 16'h0080; tick();
        chk("R6 stop cleared", status[7], 0);
        chk("R4 irq off", irq, 0);
        clr_we = 1; clr_wdata = 16'h0400; ev_nack = 1; tick();
        chk("R6 set wins", status[10], 1);
        bus_busy = 1; ien_we = 1; ien_wdata = 16'h0200; tick();
        chk("R3 busy live", status[9], 1);
        chk("R4 irq from busy", irq, 1);
        bus_busy = 0; #1;
        chk("R3 busy follows", status[9], 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule